// File: doc/BRIEF.md
# Segment Register Load Sequencer

This block carries out a move into one of the segment registers. It accepts a decoded request made of three parts: the 3-bit register field that names the target segment register, a flag that says whether the core runs in real mode, and the 16-bit selector value. From that request it runs the load sequence and drives one write port into the segment register file.

In real mode no descriptor table is touched. The segment base is formed directly from the selector, and then the selector is stored. In protected mode a selector that is not null goes through a fixed chain. First an external selector checker returns the descriptor address or a fault. Next the 8-byte descriptor is read in one access over a flat memory read port whose base is zero. A combinational descriptor decoder turns that descriptor into base, limit and attributes, and these are written together. The selector is always written last. A null selector skips the table walk for data segments, while for the stack segment it raises a protection fault. An illegal target raises an invalid-opcode fault.

Top module: `seg_load_seq`

## Requirements
- R1: A request whose register field is 1 (the code segment) produces a fault pulse with fault_kind 1 (invalid opcode) and fault_code 0, and no segment register write, in both modes.
- R2: Register fields 6 and 7 produce the same invalid-opcode fault as R1; fields 0, 3, 4 and 5 follow the data-segment path and field 2 follows the stack-segment path.
- R3: In real mode no checker request and no memory read are issued. In the first cycle after acceptance, the base of the target is written as the zero-extended selector times 16. The selector is written in the next cycle.
- R4: In protected mode, a selector with bits 15..2 all zero counts as null. A null selector on a non-stack target issues no checker request and no read; the only effect is a selector write in the first cycle after acceptance.
- R5: In protected mode, a null selector on the stack target (field 2) produces fault_kind 2 (general protection) with fault_code 0 in the first cycle after acceptance, and nothing is written.
- R6: A non-null protected selector raises chk_req with chk_sel equal to the selector from the first cycle after acceptance until chk_rsp_valid. A checker fault then gives fault_kind 2 with fault_code equal to the selector in the next cycle, and nothing is written.
- R7: After a good checker response, mem_rd_req is held with mem_rd_addr equal to the checker address until mem_rd_valid, and this 64-bit read is the only one.
- R8: In the cycle after the read data arrives, that data is presented on dec_desc. If dec_fault is low, base, limit and attributes are written in that same cycle. If dec_fault is high, fault_kind 2 with fault_code equal to the selector follows in the next cycle, and nothing is written.
- R9: The selector write comes in the cycle right after the base/limit/attribute write. No write of any kind follows it within the same request.
- R10: After reset, busy is low and all write and fault outputs are low. busy is high from the cycle after acceptance through the cycle of the selector write or the fault. Requests that arrive while busy is high are ignored.
- R11: A fault is a single-cycle pulse. The fault pulse, the base write and the selector write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised inside |
| req_valid | input | 1 | Request present; accepted when busy is low |
| req_reg | input | 3 | Target segment register field |
| req_real | input | 1 | 1 = real mode, 0 = protected mode |
| req_sel | input | 16 | Selector value to load |
| busy | output | 1 | Sequence in progress |
| chk_req | output | 1 | Request to the selector checker |
| chk_sel | output | 16 | Selector handed to the checker |
| chk_rsp_valid | input | 1 | Checker response present |
| chk_fault | input | 1 | Checker rejected the selector |
| chk_addr | input | 32 | Descriptor address from the checker |
| mem_rd_req | output | 1 | Descriptor read request |
| mem_rd_addr | output | 32 | Flat read address |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 64 | Descriptor read data |
| dec_desc | output | 64 | Descriptor handed to the decoder |
| dec_fault | input | 1 | Decoder rejected the descriptor |
| dec_base | input | 32 | Decoded base |
| dec_limit | input | 32 | Decoded limit |
| dec_attr | input | 8 | Decoded attributes |
| seg_idx | output | 3 | Target segment register index |
| seg_base_we | output | 1 | Base write enable |
| seg_base | output | 32 | Base write data |
| seg_limit_we | output | 1 | Limit write enable |
| seg_limit | output | 32 | Limit write data |
| seg_attr_we | output | 1 | Attribute write enable |
| seg_attr | output | 8 | Attribute write data |
| seg_sel_we | output | 1 | Selector write enable |
| seg_sel | output | 16 | Selector write data |
| fault_valid | output | 1 | Fault pulse |
| fault_kind | output | 2 | 1 = invalid opcode, 2 = general protection |
| fault_code | output | 16 | Fault error code |

## Verification
The block is driven with every register field in both modes, with null selectors (including ones whose low two requested-privilege bits are set), with non-null selectors that pass, selectors the checker rejects and descriptors the decoder rejects. These cases separate the five routes a request can take, and they show that nothing is written when a fault aborts a load. Checker and memory latencies of zero and of several cycles show that the block waits on the handshakes and does not count fixed cycles. A request held high, with changing contents, during a long walk shows that requests are ignored while busy.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;

  // sequencer states
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_REAL_BASE = 3'd1,
    ST_CHECK     = 3'd2,
    ST_FETCH     = 3'd3,
    ST_DECODE    = 3'd4,
    ST_SEL       = 3'd5,
    ST_FAULT     = 3'd6
  } st_e;

  // route a fresh request takes
  typedef enum logic [2:0] {
    RT_UD      = 3'd0,
    RT_REAL    = 3'd1,
    RT_SKIP    = 3'd2,
    RT_NULL_GP = 3'd3,
    RT_WALK    = 3'd4
  } route_e;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_UD   = 2'd1,
    FK_GP   = 2'd2
  } fault_kind_e;

  // register field values whose behaviour differs
  localparam int unsigned SREG_CODE  = 1;
  localparam int unsigned SREG_STACK = 2;
  localparam int unsigned SREG_LAST  = 5;

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/seg_req_classify.sv
module seg_req_classify
  import seg_load_pkg::*;
#(
  parameter int unsigned SEL_W = 16,
  parameter int unsigned REG_W = 3
) (
  input  logic [REG_W-1:0] reg_fld,
  input  logic             real_mode,
  input  logic [SEL_W-1:0] sel,
  output route_e           route
);

  localparam int unsigned RPL_W = 2;

  logic illegal_tgt;
  logic is_null;
  logic is_stack;

  always_comb begin
    illegal_tgt = (reg_fld == REG_W'(SREG_CODE)) || (reg_fld > REG_W'(SREG_LAST));
    is_stack    = (reg_fld == REG_W'(SREG_STACK));
    // null: table index and table bit are zero, requested privilege ignored
    is_null     = ((sel >> RPL_W) == '0);

    if (illegal_tgt) begin
      route = RT_UD;
    end else if (real_mode) begin
      route = RT_REAL;
    end else if (is_null && is_stack) begin
      route = RT_NULL_GP;
    end else if (is_null) begin
      route = RT_SKIP;
    end else begin
      route = RT_WALK;
    end
  end

endmodule

// File: rtl/seg_load_ctrl.sv
module seg_load_ctrl
  import seg_load_pkg::*;
#(
  parameter int unsigned SEL_W  = 16,
  parameter int unsigned REG_W  = 3,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DESC_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [REG_W-1:0]  req_reg,
  input  logic              req_real,
  input  logic [SEL_W-1:0]  req_sel,
  input  route_e            route,
  input  logic              chk_rsp_valid,
  input  logic              chk_fault,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              mem_rd_valid,
  input  logic [DESC_W-1:0] mem_rd_data,
  input  logic              dec_fault,
  output st_e               state,
  output logic [REG_W-1:0]  reg_q,
  output logic              real_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DESC_W-1:0] desc_q,
  output fault_kind_e       fk_q,
  output logic [SEL_W-1:0]  fcode_q
);

  st_e         state_d;
  logic        req_ld;
  logic        addr_ld;
  logic        desc_ld;
  logic        flt_ld;
  fault_kind_e fk_d;
  logic [SEL_W-1:0] fcode_d;

  // next-state process
  always_comb begin
    state_d = state;
    req_ld  = 1'b0;
    addr_ld = 1'b0;
    desc_ld = 1'b0;
    flt_ld  = 1'b0;
    fk_d    = FK_NONE;
    fcode_d = '0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          req_ld = 1'b1;
          unique case (route)
            RT_UD: begin
              state_d = ST_FAULT;
              flt_ld  = 1'b1;
              fk_d    = FK_UD;
            end
            RT_NULL_GP: begin
              state_d = ST_FAULT;
              flt_ld  = 1'b1;
              fk_d    = FK_GP;
            end
            RT_REAL:  state_d = ST_REAL_BASE;
            RT_SKIP:  state_d = ST_SEL;
            default:  state_d = ST_CHECK;
          endcase
        end
      end
      ST_REAL_BASE: state_d = ST_SEL;
      ST_CHECK: begin
        if (chk_rsp_valid) begin
          if (chk_fault) begin
            state_d = ST_FAULT;
            flt_ld  = 1'b1;
            fk_d    = FK_GP;
            fcode_d = sel_q;
          end else begin
            state_d = ST_FETCH;
            addr_ld = 1'b1;
          end
        end
      end
      ST_FETCH: begin
        if (mem_rd_valid) begin
          state_d = ST_DECODE;
          desc_ld = 1'b1;
        end
      end
      ST_DECODE: begin
        if (dec_fault) begin
          state_d = ST_FAULT;
          flt_ld  = 1'b1;
          fk_d    = FK_GP;
          fcode_d = sel_q;
        end else begin
          state_d = ST_SEL;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fk_q    <= FK_NONE;
      fcode_q <= '0;
    end else begin
      state <= state_d;
      if (flt_ld) begin
        fk_q    <= fk_d;
        fcode_q <= fcode_d;
      end
    end
  end

  // data registers, loaded under explicit enables
  always_ff @(posedge clk) begin
    if (req_ld) begin
      reg_q  <= req_reg;
      real_q <= req_real;
      sel_q  <= req_sel;
    end
    if (addr_ld) begin
      addr_q <= chk_addr;
    end
    if (desc_ld) begin
      desc_q <= mem_rd_data;
    end
  end

  AST_REQ_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> ($stable(sel_q) && $stable(reg_q))); // R10

  AST_FETCH_AFTER_GOOD_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH && $past(state) != ST_FETCH) |->
      ($past(state) == ST_CHECK && $past(chk_rsp_valid) && !$past(chk_fault))); // R7

  AST_NO_WALK_IN_REAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && real_q) |-> (state != ST_CHECK && state != ST_FETCH)); // R3

endmodule

// File: rtl/seg_load_outputs.sv
module seg_load_outputs
  import seg_load_pkg::*;
#(
  parameter int unsigned SEL_W   = 16,
  parameter int unsigned REG_W   = 3,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DESC_W  = 64,
  parameter int unsigned BASE_W  = 32,
  parameter int unsigned LIMIT_W = 32,
  parameter int unsigned ATTR_W  = 8,
  parameter int unsigned SHIFT   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  st_e                state,
  input  logic [REG_W-1:0]   reg_q,
  input  logic               real_q,
  input  logic [SEL_W-1:0]   sel_q,
  input  logic [ADDR_W-1:0]  addr_q,
  input  logic [DESC_W-1:0]  desc_q,
  input  fault_kind_e        fk_q,
  input  logic [SEL_W-1:0]   fcode_q,
  input  logic               dec_fault,
  input  logic [BASE_W-1:0]  dec_base,
  input  logic [LIMIT_W-1:0] dec_limit,
  input  logic [ATTR_W-1:0]  dec_attr,
  output logic               busy,
  output logic               chk_req,
  output logic [SEL_W-1:0]   chk_sel,
  output logic               mem_rd_req,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  output logic [DESC_W-1:0]  dec_desc,
  output logic [REG_W-1:0]   seg_idx,
  output logic               seg_base_we,
  output logic [BASE_W-1:0]  seg_base,
  output logic               seg_limit_we,
  output logic [LIMIT_W-1:0] seg_limit,
  output logic               seg_attr_we,
  output logic [ATTR_W-1:0]  seg_attr,
  output logic               seg_sel_we,
  output logic [SEL_W-1:0]   seg_sel,
  output logic               fault_valid,
  output logic [1:0]         fault_kind,
  output logic [SEL_W-1:0]   fault_code
);

  localparam int unsigned REAL_W = SEL_W + SHIFT;

  logic [BASE_W-1:0] real_base;
  logic              desc_ok;

  // real-mode base: selector scaled by 2**SHIFT, fitted to the base width
  generate
    if (BASE_W >= REAL_W) begin : g_real_wide
      assign real_base = BASE_W'({sel_q, {SHIFT{1'b0}}});
    end else begin : g_real_narrow
      logic [REAL_W-1:0] real_full;
      assign real_full = {sel_q, {SHIFT{1'b0}}};
      assign real_base = real_full[BASE_W-1:0];
    end
  endgenerate

  always_comb begin
    desc_ok      = (state == ST_DECODE) && !dec_fault;
    busy         = (state != ST_IDLE);
    chk_req      = (state == ST_CHECK);
    chk_sel      = sel_q;
    mem_rd_req   = (state == ST_FETCH);
    mem_rd_addr  = addr_q;
    dec_desc     = desc_q;
    seg_idx      = reg_q;
    seg_base_we  = (state == ST_REAL_BASE) || desc_ok;
    seg_base     = (state == ST_REAL_BASE) ? real_base : dec_base;
    seg_limit_we = desc_ok;
    seg_limit    = dec_limit;
    seg_attr_we  = desc_ok;
    seg_attr     = dec_attr;
    seg_sel_we   = (state == ST_SEL);
    seg_sel      = sel_q;
    fault_valid  = (state == ST_FAULT);
    fault_kind   = fault_valid ? fk_q : FK_NONE;
    fault_code   = fault_valid ? fcode_q : '0;
  end

  AST_NO_CODE_SEG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_base_we || seg_sel_we) |-> (seg_idx != REG_W'(SREG_CODE))); // R1

  AST_NO_HIGH_IDX_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_base_we || seg_sel_we) |-> (seg_idx <= REG_W'(SREG_LAST))); // R2

  AST_SEL_FOLLOWS_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    seg_limit_we |=> seg_sel_we); // R9

  AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seg_base_we, seg_sel_we, fault_valid})); // R11

  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid); // R11

  AST_REAL_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && real_q) |-> (!chk_req && !mem_rd_req)); // R3

endmodule

// File: rtl/seg_load_seq.sv
module seg_load_seq
  import seg_load_pkg::*;
#(
  parameter int unsigned SEL_W   = 16,
  parameter int unsigned REG_W   = 3,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DESC_W  = 64,
  parameter int unsigned BASE_W  = 32,
  parameter int unsigned LIMIT_W = 32,
  parameter int unsigned ATTR_W  = 8,
  parameter int unsigned SHIFT   = 4,
  parameter int unsigned RST_STG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [REG_W-1:0]   req_reg,
  input  logic               req_real,
  input  logic [SEL_W-1:0]   req_sel,
  output logic               busy,
  output logic               chk_req,
  output logic [SEL_W-1:0]   chk_sel,
  input  logic               chk_rsp_valid,
  input  logic               chk_fault,
  input  logic [ADDR_W-1:0]  chk_addr,
  output logic               mem_rd_req,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [DESC_W-1:0]  mem_rd_data,
  output logic [DESC_W-1:0]  dec_desc,
  input  logic               dec_fault,
  input  logic [BASE_W-1:0]  dec_base,
  input  logic [LIMIT_W-1:0] dec_limit,
  input  logic [ATTR_W-1:0]  dec_attr,
  output logic [REG_W-1:0]   seg_idx,
  output logic               seg_base_we,
  output logic [BASE_W-1:0]  seg_base,
  output logic               seg_limit_we,
  output logic [LIMIT_W-1:0] seg_limit,
  output logic               seg_attr_we,
  output logic [ATTR_W-1:0]  seg_attr,
  output logic               seg_sel_we,
  output logic [SEL_W-1:0]   seg_sel,
  output logic               fault_valid,
  output logic [1:0]         fault_kind,
  output logic [SEL_W-1:0]   fault_code
);

  logic              rst_n_s;
  route_e            route;
  st_e               state;
  logic [REG_W-1:0]  reg_q;
  logic              real_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DESC_W-1:0] desc_q;
  fault_kind_e       fk_q;
  logic [SEL_W-1:0]  fcode_q;

  seg_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  seg_req_classify #(.SEL_W(SEL_W), .REG_W(REG_W)) u_cls (
    .reg_fld   (req_reg),
    .real_mode (req_real),
    .sel       (req_sel),
    .route     (route)
  );

  seg_load_ctrl #(
    .SEL_W(SEL_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .DESC_W(DESC_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .req_valid     (req_valid),
    .req_reg       (req_reg),
    .req_real      (req_real),
    .req_sel       (req_sel),
    .route         (route),
    .chk_rsp_valid (chk_rsp_valid),
    .chk_fault     (chk_fault),
    .chk_addr      (chk_addr),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_data   (mem_rd_data),
    .dec_fault     (dec_fault),
    .state         (state),
    .reg_q         (reg_q),
    .real_q        (real_q),
    .sel_q         (sel_q),
    .addr_q        (addr_q),
    .desc_q        (desc_q),
    .fk_q          (fk_q),
    .fcode_q       (fcode_q)
  );

  seg_load_outputs #(
    .SEL_W(SEL_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .DESC_W(DESC_W),
    .BASE_W(BASE_W), .LIMIT_W(LIMIT_W), .ATTR_W(ATTR_W), .SHIFT(SHIFT)
  ) u_out (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .state        (state),
    .reg_q        (reg_q),
    .real_q       (real_q),
    .sel_q        (sel_q),
    .addr_q       (addr_q),
    .desc_q       (desc_q),
    .fk_q         (fk_q),
    .fcode_q      (fcode_q),
    .dec_fault    (dec_fault),
    .dec_base     (dec_base),
    .dec_limit    (dec_limit),
    .dec_attr     (dec_attr),
    .busy         (busy),
    .chk_req      (chk_req),
    .chk_sel      (chk_sel),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .dec_desc     (dec_desc),
    .seg_idx      (seg_idx),
    .seg_base_we  (seg_base_we),
    .seg_base     (seg_base),
    .seg_limit_we (seg_limit_we),
    .seg_limit    (seg_limit),
    .seg_attr_we  (seg_attr_we),
    .seg_attr     (seg_attr),
    .seg_sel_we   (seg_sel_we),
    .seg_sel      (seg_sel),
    .fault_valid  (fault_valid),
    .fault_kind   (fault_kind),
    .fault_code   (fault_code)
  );

  AST_GP_ONLY_FROM_PROT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fault_valid && fault_kind == 2'd2) |-> !real_q); // R5

endmodule

// File: tb/seg_load_seq_tb_top.sv
`timescale 1ns/1ps
module seg_load_seq_tb_top;

  localparam logic [31:0] GDT_BASE = 32'h0010_0000;
  localparam int          MAX_IDX  = 15;

  typedef struct {
    logic        busy;
    logic        chk;
    logic [15:0] csel;
    logic        mem;
    logic [31:0] maddr;
    logic        bwe;
    logic [31:0] base;
    logic        lwe;
    logic [31:0] lim;
    logic        awe;
    logic [7:0]  attr;
    logic        swe;
    logic [15:0] sel;
    logic [2:0]  idx;
    logic        fv;
    logic [1:0]  fk;
    logic [15:0] fc;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_reg = '0;
  logic        req_real = 1'b0;
  logic [15:0] req_sel = '0;
  logic        busy;
  logic        chk_req;
  logic [15:0] chk_sel;
  logic        chk_rsp_valid = 1'b0;
  logic        chk_fault = 1'b0;
  logic [31:0] chk_addr = '0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic [63:0] dec_desc;
  logic        dec_fault;
  logic [31:0] dec_base;
  logic [31:0] dec_limit;
  logic [7:0]  dec_attr;
  logic [2:0]  seg_idx;
  logic        seg_base_we;
  logic [31:0] seg_base;
  logic        seg_limit_we;
  logic [31:0] seg_limit;
  logic        seg_attr_we;
  logic [7:0]  seg_attr;
  logic        seg_sel_we;
  logic [15:0] seg_sel;
  logic        fault_valid;
  logic [1:0]  fault_kind;
  logic [15:0] fault_code;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int chk_lat = 2;
  int mem_lat = 3;
  int ccnt    = 0;
  int mcnt    = 0;
  rec_t  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  // behavioural descriptor decoder
  assign dec_base  = {dec_desc[63:56], dec_desc[39:16]};
  assign dec_limit = {12'h000, dec_desc[51:48], dec_desc[15:0]};
  assign dec_attr  = dec_desc[47:40];
  assign dec_fault = !dec_desc[47];

  seg_load_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_reg(req_reg), .req_real(req_real), .req_sel(req_sel),
    .busy(busy),
    .chk_req(chk_req), .chk_sel(chk_sel), .chk_rsp_valid(chk_rsp_valid),
    .chk_fault(chk_fault), .chk_addr(chk_addr),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .dec_desc(dec_desc), .dec_fault(dec_fault), .dec_base(dec_base),
    .dec_limit(dec_limit), .dec_attr(dec_attr),
    .seg_idx(seg_idx), .seg_base_we(seg_base_we), .seg_base(seg_base),
    .seg_limit_we(seg_limit_we), .seg_limit(seg_limit),
    .seg_attr_we(seg_attr_we), .seg_attr(seg_attr),
    .seg_sel_we(seg_sel_we), .seg_sel(seg_sel),
    .fault_valid(fault_valid), .fault_kind(fault_kind), .fault_code(fault_code)
  );

  function automatic logic [63:0] mdata(input logic [31:0] a);
    logic [7:0] ab;
    ab = (a[9:3] == 7'd9) ? 8'h12 : 8'h92;
    return {a[15:8], 4'hC, a[3:0] ^ 4'h5, ab, a[23:0], 16'hFFFF ^ a[15:0]};
  endfunction

  function automatic rec_t blank();
    rec_t r;
    r = '{busy:1'b1, chk:1'b0, csel:16'h0, mem:1'b0, maddr:32'h0, bwe:1'b0, base:32'h0,
          lwe:1'b0, lim:32'h0, awe:1'b0, attr:8'h0, swe:1'b0, sel:16'h0, idx:3'h0,
          fv:1'b0, fk:2'h0, fc:16'h0};
    return r;
  endfunction

  task automatic push(input rec_t r, input string t);
    exp_q.push_back(r);
    tag_q.push_back(t);
  endtask

  // reference model: builds the expected per-cycle trace of one request
  task automatic expect_req(input logic [2:0] r, input logic rl, input logic [15:0] s,
                            input string t);
    rec_t e;
    logic [31:0] a;
    logic [63:0] d;
    if (r == 3'd1 || r >= 3'd6) begin
      e = blank(); e.fv = 1'b1; e.fk = 2'd1; push(e, t);
    end else if (rl) begin
      e = blank(); e.bwe = 1'b1; e.base = {12'h000, s, 4'h0}; e.idx = r; push(e, t);
      e = blank(); e.swe = 1'b1; e.sel = s; e.idx = r; push(e, t);
    end else if (s[15:2] == 14'h0) begin
      e = blank();
      if (r == 3'd2) begin e.fv = 1'b1; e.fk = 2'd2; end
      else begin e.swe = 1'b1; e.sel = s; e.idx = r; end
      push(e, t);
    end else begin
      for (int i = 0; i <= chk_lat; i++) begin
        e = blank(); e.chk = 1'b1; e.csel = s; push(e, t);
      end
      if (int'(s[15:3]) > MAX_IDX) begin
        e = blank(); e.fv = 1'b1; e.fk = 2'd2; e.fc = s; push(e, t);
      end else begin
        a = GDT_BASE + {16'h0, s[15:3], 3'b000};
        for (int i = 0; i <= mem_lat; i++) begin
          e = blank(); e.mem = 1'b1; e.maddr = a; push(e, t);
        end
        d = mdata(a);
        if (!d[47]) begin
          e = blank(); push(e, t);
          e = blank(); e.fv = 1'b1; e.fk = 2'd2; e.fc = s; push(e, t);
        end else begin
          e = blank(); e.idx = r;
          e.bwe = 1'b1; e.base = {d[63:56], d[39:16]};
          e.lwe = 1'b1; e.lim = {12'h000, d[51:48], d[15:0]};
          e.awe = 1'b1; e.attr = d[47:40];
          push(e, t);
          e = blank(); e.swe = 1'b1; e.sel = s; e.idx = r; push(e, t);
        end
      end
    end
  endtask

  // one clock: compare outputs against the model, then update responders
  task automatic step();
    rec_t  e;
    string t;
    logic  bad;
    @(negedge clk);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
    end else begin
      e = blank(); e.busy = 1'b0; t = "R10";
    end
    bad = (busy !== e.busy) || (chk_req !== e.chk) || (e.chk && chk_sel !== e.csel) ||
          (mem_rd_req !== e.mem) || (e.mem && mem_rd_addr !== e.maddr) ||
          (seg_base_we !== e.bwe) || (e.bwe && seg_base !== e.base) ||
          (seg_limit_we !== e.lwe) || (e.lwe && seg_limit !== e.lim) ||
          (seg_attr_we !== e.awe) || (e.awe && seg_attr !== e.attr) ||
          (seg_sel_we !== e.swe) || (e.swe && seg_sel !== e.sel) ||
          ((e.bwe || e.swe) && seg_idx !== e.idx) ||
          (fault_valid !== e.fv) || (fault_kind !== e.fk) || (fault_code !== e.fc);
    n_tests++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s t=%0t actual busy=%0b chk=%0b/%h mem=%0b/%h bwe=%0b/%h lwe=%0b/%h awe=%0b/%h swe=%0b/%h idx=%0d flt=%0b/%0d/%h expected busy=%0b chk=%0b/%h mem=%0b/%h bwe=%0b/%h lwe=%0b/%h awe=%0b/%h swe=%0b/%h idx=%0d flt=%0b/%0d/%h",
               t, $time, busy, chk_req, chk_sel, mem_rd_req, mem_rd_addr, seg_base_we, seg_base,
               seg_limit_we, seg_limit, seg_attr_we, seg_attr, seg_sel_we, seg_sel, seg_idx,
               fault_valid, fault_kind, fault_code,
               e.busy, e.chk, e.csel, e.mem, e.maddr, e.bwe, e.base, e.lwe, e.lim, e.awe, e.attr,
               e.swe, e.sel, e.idx, e.fv, e.fk, e.fc);
    end
    // checker responder
    if (chk_req) begin
      if (ccnt == chk_lat) begin
        chk_rsp_valid = 1'b1;
        chk_fault     = (int'(chk_sel[15:3]) > MAX_IDX);
        chk_addr      = GDT_BASE + {16'h0, chk_sel[15:3], 3'b000};
        ccnt = 0;
      end else begin
        chk_rsp_valid = 1'b0;
        ccnt++;
      end
    end else begin
      chk_rsp_valid = 1'b0;
      ccnt = 0;
    end
    // memory responder
    if (mem_rd_req) begin
      if (mcnt == mem_lat) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = mdata(mem_rd_addr);
        mcnt = 0;
      end else begin
        mem_rd_valid = 1'b0;
        mcnt++;
      end
    end else begin
      mem_rd_valid = 1'b0;
      mcnt = 0;
    end
  endtask

  // issue one request; hold > 0 keeps req_valid high with other contents while busy
  task automatic run_req(input logic [2:0] r, input logic rl, input logic [15:0] s,
                         input string t, input int hold);
    expect_req(r, rl, s, t);
    req_valid = 1'b1; req_reg = r; req_real = rl; req_sel = s;
    step();
    for (int i = 0; i < hold; i++) begin
      req_reg = 3'd3; req_real = 1'b1; req_sel = 16'hBEEF ^ 16'(i);
      step();
    end
    req_valid = 1'b0;
    while (exp_q.size() > 0) step();
    step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL R10 watchdog expired: actual busy=%0b expected run to finish", busy);
      $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  initial begin
    // reset state
    for (int i = 0; i < 3; i++) step();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();

    // R3: real mode, data and stack targets
    run_req(3'd0, 1'b1, 16'h1234, "R3", 0);
    run_req(3'd2, 1'b1, 16'h0000, "R3", 0);
    run_req(3'd5, 1'b1, 16'hFFFF, "R3", 0);
    // R1: code segment target in both modes
    run_req(3'd1, 1'b0, 16'h0010, "R1", 0);
    run_req(3'd1, 1'b1, 16'h0010, "R1", 0);
    // R2: illegal high fields, legal data fields
    run_req(3'd6, 1'b0, 16'h0018, "R2", 0);
    run_req(3'd7, 1'b1, 16'h0018, "R2", 0);
    // R4: null selectors on data targets, privilege bits ignored
    run_req(3'd3, 1'b0, 16'h0003, "R4", 0);
    run_req(3'd0, 1'b0, 16'h0000, "R4", 0);
    // R5: null stack selectors
    run_req(3'd2, 1'b0, 16'h0002, "R5", 0);
    run_req(3'd2, 1'b0, 16'h0000, "R5", 0);
    // R7 R8 R9: full walks
    run_req(3'd4, 1'b0, 16'h0018, "R9", 0);
    run_req(3'd2, 1'b0, 16'h002B, "R8", 0);
    // R6: checker rejects
    run_req(3'd5, 1'b0, 16'h00A0, "R6", 0);
    // R8: decoder rejects (index 9 is marked not present)
    run_req(3'd0, 1'b0, 16'h0048, "R8", 0);
    // R7: zero latency on both handshakes
    chk_lat = 0; mem_lat = 0;
    run_req(3'd3, 1'b0, 16'h0008, "R7", 0);
    run_req(3'd5, 1'b0, 16'h0080, "R6", 0);
    // R10: requests while busy are ignored
    chk_lat = 4; mem_lat = 5;
    run_req(3'd0, 1'b0, 16'h0010, "R10", 6);
    run_req(3'd3, 1'b1, 16'h00F0, "R10", 1);
    // R11: back-to-back faults
    chk_lat = 1; mem_lat = 1;
    run_req(3'd1, 1'b0, 16'h0000, "R11", 0);
    run_req(3'd2, 1'b0, 16'h0001, "R11", 0);
    run_req(3'd4, 1'b0, 16'h0078, "R11", 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule